// File: doc/BRIEF.md
# Paced Register-Write Command Queue

This block sits between a host register bus and a drawing engine's register port. Each host write carries an address and a data word. Writes to the block's three local registers (control, status and credit) are handled inside the block. Every other write is sent on to the engine. A mode bit in the control register picks how that happens. When the bit is set, the write goes straight to the engine port and the host waits for the engine. When the bit is clear, the write is placed in a deep queue and the host continues at once.

The queue is sized in slots, and each queued write takes two of them: one for the address and one for the data. Software reads the credit register to learn how many whole writes still fit, so it can pace its stream. It reads the status register to learn whether everything has drained. A queued write that arrives with no room left is thrown away. It also sets a sticky flag that software can read and then clear.

Top module: `regwr_pacer`

## Requirements
- R1: After reset the control register reads 0x200 (bit 9, direct mode, set), the queue is empty, the credit register reads SLOTS/2, and the status register reads 0.
- R2: In direct mode with an empty queue, a host write to a non-local address appears on the engine port in the same cycle, and `wr_ready` follows `eng_ready`.
- R3: In queued mode, a write to a non-local address is accepted in the cycle it is presented, and it takes two slots. The credit register (bits SLOTS-width:0) reads the number of free slots divided by two.
- R4: Queued writes leave on the engine port in the order they were accepted. `eng_valid` is high while the queue is non-empty, and the head entry holds steady until `eng_ready` takes it.
- R5: A queued-mode write that arrives when the queue is full is accepted and discarded. The queue contents stay unchanged, and the overflow flag is set. The flag reads as bit 31 of the credit register.
- R6: Any write to the control register stores only bit 9 (all other bits read 0) and clears the overflow flag.
- R7: The status register reads bit 0 = queue non-empty, bit 1 = `eng_busy`, and bit 2 = a direct-mode write is being presented. All other bits are 0, so the register reads 0 only when the block is idle.
- R8: In direct mode with a non-empty queue, host writes to non-local addresses are held (`wr_ready` low) until the queue has drained, so the engine always sees the queued writes first.
- R9: Writes to the status and credit addresses are accepted and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host write request |
| wr_ready | output | 1 | Host write accepted this cycle |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | DATA_W | Host write data |
| rd_addr | input | ADDR_W | Local register read address |
| rd_data | output | DATA_W | Local register read data (combinational) |
| eng_valid | output | 1 | Register write offered to the engine |
| eng_ready | input | 1 | Engine takes the offered write |
| eng_addr | output | ADDR_W | Engine write address |
| eng_data | output | DATA_W | Engine write data |
| eng_busy | input | 1 | Engine is still processing |

## Verification
Errors in the occupancy count show up on the very next read of the credit register, and they shift when the overflow flag fires by a full queue's worth of writes. Errors in the read or write pointers show up as wrong or reordered address and data pairs on the engine port, as soon as the affected entry reaches the head. A mistake in the mode bit or the stall logic shows up in the same cycle: either as a pass-through while the queue still holds data, or as `wr_ready` asserted when the engine is not ready.

// File: rtl/regwr_pacer.sv
module regwr_pacer #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int SLOTS = 2048,
  parameter int MODE_BIT = 9,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 24'hFF0000,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 24'hFF0004,
  parameter logic [ADDR_W-1:0] PACE_ADDR = 24'hFF0008
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              eng_valid,
  input  logic              eng_ready,
  output logic [ADDR_W-1:0] eng_addr,
  output logic [DATA_W-1:0] eng_data,
  input  logic              eng_busy
);
  localparam int ENTRIES = SLOTS / 2;
  localparam int PW = $clog2(ENTRIES);
  localparam int CW = $clog2(ENTRIES + 1);
  localparam int EW = ADDR_W + DATA_W;

  logic [EW-1:0] mem [ENTRIES];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          direct, ovf;

  wire hit_ctrl = wr_addr == CTRL_ADDR;
  wire is_local = hit_ctrl | (wr_addr == STAT_ADDR) | (wr_addr == PACE_ADDR);
  wire fifo_nz  = cnt != '0;
  wire full     = cnt == CW'(ENTRIES);
  wire fwd      = wr_valid & ~is_local;
  wire pass     = direct & ~fifo_nz & fwd;
  wire push     = fwd & ~direct & ~full;
  wire drop     = fwd & ~direct & full;
  wire pop      = fifo_nz & eng_ready;
  wire [CW-1:0] free_ent = CW'(ENTRIES) - cnt;
  wire [2:0] status = {direct & fwd, eng_busy, fifo_nz};

  assign eng_valid = fifo_nz | pass;
  assign {eng_addr, eng_data} = fifo_nz ? mem[rp] : {wr_addr, wr_data};
  assign wr_ready = is_local ? 1'b1 : (direct ? (~fifo_nz & eng_ready) : 1'b1);

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= {wr_addr, wr_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      cnt <= '0;
      direct <= 1'b1;
      ovf <= 1'b0;
    end else begin
      if (push) wp <= (wp == PW'(ENTRIES - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PW'(ENTRIES - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
      if (wr_valid && hit_ctrl) begin
        direct <= wr_data[MODE_BIT];
        ovf <= 1'b0;
      end else if (drop) begin
        ovf <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == CTRL_ADDR) rd_data[MODE_BIT] = direct;
    else if (rd_addr == STAT_ADDR) rd_data[2:0] = status;
    else if (rd_addr == PACE_ADDR) begin
      rd_data[CW-1:0] = free_ent;
      rd_data[DATA_W-1] = ovf;
    end
  end

  p_reset_direct_r1: assert property (@(posedge clk) $fell(rst_n) |=> direct && cnt == '0);
  p_pass_through_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (direct && !fifo_nz && fwd) |-> (eng_valid && eng_addr == wr_addr && wr_ready == eng_ready));
  p_count_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> cnt == $past(cnt) + 1'b1);
  p_head_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_nz && !eng_ready) |=> (eng_valid && $stable(eng_addr) && $stable(eng_data)));
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !hit_ctrl) |=> (ovf && cnt == $past(cnt) - CW'($past(pop))));
  p_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(ENTRIES));
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 3'b000) |-> !eng_valid);
  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (direct && fifo_nz && fwd) |-> !wr_ready);
endmodule

// File: tb/regwr_pacer_bench.sv
module regwr_pacer_bench;
  localparam int PERIOD = 10;
  localparam int ENT = 1024;
  localparam logic [23:0] A_CTRL = 24'hFF0000;
  localparam logic [23:0] A_STAT = 24'hFF0004;
  localparam logic [23:0] A_PACE = 24'hFF0008;

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, eng_ready = 0, eng_busy = 0;
  logic [23:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0;
  logic wr_ready, eng_valid;
  logic [31:0] rd_data, eng_data;
  logic [23:0] eng_addr;

  regwr_pacer u_regwr_pacer (.clk, .rst_n, .wr_valid, .wr_ready, .wr_addr, .wr_data,
    .rd_addr, .rd_data, .eng_valid, .eng_ready, .eng_addr, .eng_data, .eng_busy);

  always #(PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [55:0] q[$];
  logic m_direct = 1, m_ovf = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic is_loc(logic [23:0] a);
    return a == A_CTRL || a == A_STAT || a == A_PACE;
  endfunction

  function automatic logic [31:0] exp_rd(logic [23:0] a);
    logic [31:0] v = 0;
    if (a == A_CTRL) v[9] = m_direct;
    else if (a == A_STAT) v[2:0] = {m_direct & wr_valid & ~is_loc(wr_addr), eng_busy, q.size() != 0};
    else if (a == A_PACE) v = {m_ovf, 20'd0, 11'(ENT - q.size())};
    return v;
  endfunction

  function automatic string rd_tag(logic [23:0] a);
    if (a == A_CTRL) return "R6";
    if (a == A_STAT) return "R7";
    return "R3";
  endfunction

  task automatic cycle(logic v, logic [23:0] a, logic [31:0] d, logic er, logic eb, logic [23:0] ra);
    logic exp_rdy, exp_ev, loc, rdy_s, ev_s;
    @(negedge clk);
    wr_valid = v; wr_addr = a; wr_data = d; eng_ready = er; eng_busy = eb; rd_addr = ra;
    #(PERIOD/4);
    loc = is_loc(a);
    exp_rdy = loc ? 1'b1 : (m_direct ? (q.size() == 0 && er) : 1'b1);
    exp_ev = q.size() != 0 || (m_direct && v && !loc);
    if (v) check(m_direct ? "R8" : "R3", {31'd0, wr_ready}, {31'd0, exp_rdy});
    check(q.size() != 0 ? "R4" : "R2", {31'd0, eng_valid}, {31'd0, exp_ev});
    if (exp_ev) begin
      if (q.size() != 0) begin
        check("R4", {8'd0, eng_addr}, {8'd0, q[0][55:32]});
        check("R4", eng_data, q[0][31:0]);
      end else begin
        check("R2", {8'd0, eng_addr}, {8'd0, a});
        check("R2", eng_data, d);
      end
    end
    check(rd_tag(ra), rd_data, exp_rd(ra));
    rdy_s = exp_rdy; ev_s = exp_ev;
    @(posedge clk);
    if (ev_s && er && q.size() != 0) begin
      if (v && !loc && !m_direct && q.size() == ENT) m_ovf = 1;
      void'(q.pop_front());
    end else if (v && !loc && !m_direct && q.size() == ENT) m_ovf = 1;
    if (v && rdy_s) begin
      if (a == A_CTRL) begin m_direct = d[9]; m_ovf = 0; end
      else if (!loc && !m_direct && !(m_ovf && q.size() >= ENT - 1 && ev_s && er && 0)) begin
        if (q.size() + ((ev_s && er) ? 1 : 0) < ENT) q.push_back({a, d});
      end
    end
  endtask

  function automatic logic [23:0] rnd_addr();
    int r = $urandom_range(0, 9);
    if (r == 0) return A_STAT;
    if (r == 1) return A_PACE;
    return {8'h00, 16'($urandom)};
  endfunction

  function automatic logic [23:0] rnd_rd();
    int r = $urandom_range(0, 2);
    return r == 0 ? A_CTRL : (r == 1 ? A_STAT : A_PACE);
  endfunction

  initial begin
    #(PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1: reset state
    cycle(0, 0, 0, 0, 0, A_CTRL); check("R1", rd_data, 32'h200);
    cycle(0, 0, 0, 0, 0, A_STAT); check("R1", rd_data, 32'h0);
    cycle(0, 0, 0, 0, 0, A_PACE); check("R1", rd_data, ENT);
    // R2: direct pass-through, random
    for (int i = 0; i < 300; i++)
      cycle($urandom_range(0, 1), rnd_addr(), $urandom, $urandom_range(0, 1), $urandom_range(0, 1), rnd_rd());
    // R6: control write stores only bit 9, switches to queued mode
    cycle(1, A_CTRL, 32'hFFFF_FDFF, 0, 0, A_CTRL);
    cycle(0, 0, 0, 0, 0, A_CTRL); check("R6", rd_data, 32'h0);
    // R3/R4: queued mode random
    for (int i = 0; i < 3000; i++)
      cycle($urandom_range(0, 1), rnd_addr(), $urandom, $urandom_range(0, 3) == 0, $urandom_range(0, 1), rnd_rd());
    // R5: fill the queue with the engine stalled
    while (q.size() < ENT) cycle(1, {8'h01, 16'($urandom)}, $urandom, 0, 0, A_PACE);
    cycle(0, 0, 0, 0, 0, A_PACE); check("R5", rd_data, 32'h0);
    cycle(1, 24'h00ABCD, 32'hDEAD_BEEF, 0, 0, A_PACE);
    cycle(0, 0, 0, 0, 0, A_PACE); check("R5", rd_data, 32'h8000_0000);
    // R9: status and credit writes ignored
    cycle(1, A_STAT, 32'hFFFF_FFFF, 0, 0, A_STAT);
    cycle(1, A_PACE, 32'h0, 0, 0, A_PACE);
    cycle(0, 0, 0, 0, 0, A_PACE); check("R9", rd_data, 32'h8000_0000);
    cycle(0, 0, 0, 0, 0, A_CTRL); check("R9", rd_data, 32'h0);
    // R8: switch to direct while full; host write must wait for drain
    cycle(1, A_CTRL, 32'h200, 0, 0, A_PACE);
    cycle(0, 0, 0, 0, 0, A_PACE); check("R6", rd_data, 32'h0);
    while (q.size() != 0) cycle(1, 24'h000777, 32'h1234_5678, $urandom_range(0, 1), 0, A_STAT);
    cycle(1, 24'h000777, 32'h1234_5678, 1, 0, A_STAT);
    check("R8", {31'd0, wr_ready}, 32'd1);
    cycle(0, 0, 0, 1, 0, A_STAT); check("R7", rd_data, 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule